// File: doc/BRIEF.md
# EDO DRAM Device-Side Emulator

This block acts as the memory chip on an asynchronous extended-data-out DRAM interface, rebuilt as a small on-chip array. A controller, or a test harness standing in for one, drives active-low row strobe, two byte-lane column strobes, write enable and output enable, plus a multiplexed address bus. The block samples all of these on a fast system clock and detects their edges from one sample to the next. It latches the row and the column, performs full-word and single-byte reads and writes, and keeps read data on the bus until the next column strobe. A refresh cycle with the column strobe first is handled by an internal row counter.

The two byte-lane column strobes are merged into one effective strobe. It goes active with the first lane to fall and stays active until the last lane rises. Each lane still decides which half of the data bus it drives or writes. The bidirectional bus is split into `dqIn`, `dqOut` and a per-byte output enable `dqOe`. Cell decay and analog timing are not modelled. Holding the row strobe low through a refresh cycle raises a self-refresh flag.

Top module: `edo_dram_emu`

## Requirements
- R1: After reset, `dqOe` is 0, `cbrRow` is 0 and `selfRefresh` is 0.
- R2: The row is taken from `addr` on the sample where `rasN` falls, and the column on the sample where the effective column strobe falls. Only the low log2(ROWS) and log2(COLS) bits are used, so addresses alias modulo the array size.
- R3: The effective column strobe is active while `lcasN` or `ucasN` is low. A new column is latched only when both lanes were high on the previous sample. One lane rising while the other stays low neither ends the strobe nor starts a new access.
- R4: A read starts on the sample where the effective strobe is active, `oeN` is low and `weN` is high, with at least one of these newly true, inside an open row. The addressed word is on `dqOut` with `dqOe` set from the next sample on.
- R5: `dqOe[0]` (bits 7:0) is set only if `lcasN` was low during the read, and `dqOe[1]` (bits 15:8) only if `ucasN` was low. A write updates only the byte lanes whose strobe is low on the sample where the write starts.
- R6: A write starts at the later of the effective strobe falling and `weN` falling. It stores `dqIn` as sampled at the earlier of the two falling edges, or at that sample if both fall together. With `weN` held low across page cycles, each new strobe fall stores the `dqIn` present on that sample.
- R7: Read data stays on `dqOut` with `dqOe` set after the column strobe rises, while the row stays open. It changes only when the next read starts on a later strobe fall.
- R8: `dqOe` is 0 in the same cycle that `oeN` is high or `weN` is low. It is 0 from the sample after one where `rasN`, `lcasN` and `ucasN` are all high. It stays driven if `rasN` rises while a column strobe is still low.
- R9: If the effective strobe is active when `rasN` falls, the cycle is refresh-only. The address is ignored, no read or write happens, the array is unchanged, and `dqOe` stays 0 for the whole cycle.
- R10: `cbrRow` steps by one on the sample where `rasN` is high at the end of each refresh-only cycle, and wraps from ROWS-1 to 0.
- R11: In a refresh-only cycle, `selfRefresh` rises on the SELFREF_SAMPLES-th sample after the `rasN` fall. It clears on the sample after `rasN` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low |
| lcasN | input | 1 | Column strobe for bits 7:0, active low |
| ucasN | input | 1 | Column strobe for bits 15:8, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dqIn | input | DW | Data bus as driven by the controller |
| dqOut | output | DW | Data the block drives onto the bus |
| dqOe | output | 2 | Per-byte drive enable for dqOut |
| cbrRow | output | log2(ROWS) | Internal refresh row counter |
| selfRefresh | output | 1 | Self-refresh state flag |

## Verification
Embedded properties check on every cycle that the bus is undriven after a fully idle sample and throughout a refresh-only cycle. They also check that a held read word does not change between strobe falls, that each refresh-only cycle moves the row counter, and that the self-refresh flag never stands outside a refresh-only cycle. The rest can only be shown by scenarios. These are the full write-then-read sweep of the array, address aliasing, early, late, simultaneous and page-mode writes, byte-lane masking, staggered lane strobes, counter wrap-around, and the array surviving a refresh cycle that presents a write.

// File: rtl/edo_emu_pkg.sv
package edo_emu_pkg;
  // Strobes from the control FSM to the datapath, one sample wide
  typedef struct packed {
    logic       latchRow;  // capture row from address
    logic       latchCol;  // capture column from address
    logic       rdStart;   // load read word and enable output
    logic       rdHold;    // read still active, accumulate lanes
    logic       wrStart;   // commit write to the array
    logic       useLatch;  // write data comes from the held latch
    logic       capData;   // first of CAS/WE fell: hold dqIn
    logic       clearOut;  // drop held read data
    logic [1:0] lanes;     // byte-lane strobes active now
  } strobe_t;
endpackage

// File: rtl/edo_emu_ctrl.sv
module edo_emu_ctrl
  import edo_emu_pkg::*;
#(
  parameter int ROWS            = 16,
  parameter int SELFREF_SAMPLES = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rasN,
  input  logic                    lcasN,
  input  logic                    ucasN,
  input  logic                    weN,
  input  logic                    oeN,
  output strobe_t                 strb,
  output logic                    cbrActive,
  output logic [$clog2(ROWS)-1:0] cbrRow,
  output logic                    selfRefresh
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int SR_W  = $clog2(SELFREF_SAMPLES);
  localparam logic [SR_W-1:0]  SR_LIM  = SR_W'(SELFREF_SAMPLES - 1);
  localparam logic [ROW_W-1:0] ROW_TOP = ROW_W'(ROWS - 1);

  logic rasNPrev, casPrev, weNPrev, rdPrev, wrPrev;
  logic rowOpen, wdHeld;
  logic [SR_W-1:0] srCnt;

  logic casAct, rasFall, casFall, casRise, weFall, cycleEnd, rdCond, wrCond;

  always_comb begin
    casAct   = ~(lcasN & ucasN);
    rasFall  = rasNPrev & ~rasN;
    casFall  = casAct & ~casPrev;
    casRise  = ~casAct & casPrev;
    weFall   = weNPrev & ~weN;
    cycleEnd = rasN & ~casAct;
    rdCond   = casAct & ~oeN & weN & rowOpen;
    wrCond   = casAct & ~weN & rowOpen;

    strb.latchRow = rasFall & ~casAct;
    strb.latchCol = casFall & rowOpen;
    strb.rdStart  = rdCond & ~rdPrev;
    strb.rdHold   = rdCond & rdPrev;
    strb.wrStart  = wrCond & ~wrPrev;
    strb.useLatch = wdHeld;
    strb.capData  = (weFall & ~casAct) | (casFall & weN);
    strb.clearOut = casFall | cycleEnd | (rasFall & casAct);
    strb.lanes    = {~ucasN, ~lcasN};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasNPrev    <= 1'b1;
      casPrev     <= 1'b0;
      weNPrev     <= 1'b1;
      rdPrev      <= 1'b0;
      wrPrev      <= 1'b0;
      rowOpen     <= 1'b0;
      cbrActive   <= 1'b0;
      wdHeld      <= 1'b0;
      srCnt       <= '0;
      selfRefresh <= 1'b0;
      cbrRow      <= '0;
    end else begin
      rasNPrev <= rasN;
      casPrev  <= casAct;
      weNPrev  <= weN;
      rdPrev   <= rdCond;
      wrPrev   <= wrCond;

      if (strb.capData)          wdHeld <= 1'b1;
      else if (casRise || cycleEnd) wdHeld <= 1'b0;

      if (rasN) begin
        rowOpen     <= 1'b0;
        cbrActive   <= 1'b0;
        selfRefresh <= 1'b0;
        srCnt       <= '0;
        if (cbrActive) cbrRow <= (cbrRow == ROW_TOP) ? '0 : cbrRow + 1'b1;
      end else if (rasFall) begin
        rowOpen   <= ~casAct;
        cbrActive <= casAct;
        srCnt     <= '0;
      end else if (cbrActive) begin
        if (srCnt == SR_LIM) selfRefresh <= 1'b1;
        else                 srCnt <= srCnt + 1'b1;
      end
    end
  end

  // Each completed refresh-only cycle must move the counter
  assert_refresh_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cbrActive && rasN) |=> (cbrRow != $past(cbrRow)));

  // Self-refresh flag only lives inside a refresh-only cycle
  assert_selfref_in_cbr_R11: assert property (@(posedge clk) disable iff (!rstN)
    selfRefresh |-> cbrActive);
endmodule

// File: rtl/edo_emu_dp.sv
module edo_emu_dp
  import edo_emu_pkg::*;
#(
  parameter int ROWS   = 16,  // power of two
  parameter int COLS   = 16,  // power of two
  parameter int DW     = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     dqIn,
  input  logic              oeN,
  input  logic              weN,
  output logic [DW-1:0]     dqOut,
  output logic [1:0]        dqOe
);
  localparam int ROW_W     = $clog2(ROWS);
  localparam int COL_W     = $clog2(COLS);
  localparam int LANE_W    = DW / 2;
  localparam int ADDR_USED = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [DW-1:0]    mem [ROWS][COLS];
  logic [ROW_W-1:0] rowReg;
  logic [COL_W-1:0] colReg, colEff;
  logic [DW-1:0]    wdLatch, wData, dataReg;
  logic             dataValid;
  logic [1:0]       laneEn;
  logic             unusedAddrHi;

  assign unusedAddrHi = ^addr[ADDR_W-1:ADDR_USED];
  assign colEff = strb.latchCol ? addr[COL_W-1:0] : colReg;
  assign wData  = strb.useLatch ? wdLatch : dqIn;

  always_ff @(posedge clk) begin
    if (strb.latchRow) rowReg  <= addr[ROW_W-1:0];
    if (strb.latchCol) colReg  <= addr[COL_W-1:0];
    if (strb.capData)  wdLatch <= dqIn;
    if (strb.wrStart) begin
      for (int l = 0; l < 2; l++) begin
        if (strb.lanes[l]) mem[rowReg][colEff][l*LANE_W +: LANE_W] <= wData[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg   <= '0;
      dataValid <= 1'b0;
      laneEn    <= 2'b00;
    end else if (strb.rdStart) begin
      dataReg   <= mem[rowReg][colEff];
      dataValid <= 1'b1;
      laneEn    <= strb.lanes;
    end else begin
      if (strb.clearOut) dataValid <= 1'b0;
      if (strb.rdHold)   laneEn    <= laneEn | strb.lanes;
    end
  end

  assign dqOut = dataReg;

  for (genvar g = 0; g < 2; g++) begin : gLaneOe
    assign dqOe[g] = dataValid & laneEn[g] & ~oeN & weN;
  end

  // Held read word may only change when a new read loads it
  assert_edo_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !strb.rdStart && !strb.clearOut) |=> ($stable(dataReg) && dataValid));
endmodule

// File: rtl/edo_dram_emu.sv
module edo_dram_emu
  import edo_emu_pkg::*;
#(
  parameter int ROWS            = 16,
  parameter int COLS            = 16,
  parameter int DW              = 16,
  parameter int ADDR_W          = 10,
  parameter int SELFREF_SAMPLES = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rasN,
  input  logic                    lcasN,
  input  logic                    ucasN,
  input  logic                    weN,
  input  logic                    oeN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DW-1:0]           dqIn,
  output logic [DW-1:0]           dqOut,
  output logic [1:0]              dqOe,
  output logic [$clog2(ROWS)-1:0] cbrRow,
  output logic                    selfRefresh
);
  strobe_t strb;
  logic    cbrActive;

  edo_emu_ctrl #(.ROWS(ROWS), .SELFREF_SAMPLES(SELFREF_SAMPLES)) uCtrl (
    .clk(clk), .rstN(rstN), .rasN(rasN), .lcasN(lcasN), .ucasN(ucasN),
    .weN(weN), .oeN(oeN), .strb(strb), .cbrActive(cbrActive),
    .cbrRow(cbrRow), .selfRefresh(selfRefresh)
  );

  edo_emu_dp #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .dqIn(dqIn),
    .oeN(oeN), .weN(weN), .dqOut(dqOut), .dqOe(dqOe)
  );

  // Fully idle sample releases the bus on the next one
  assert_end_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rasN && lcasN && ucasN) |=> (dqOe == 2'b00));

  // Refresh-only cycle never drives the bus
  assert_cbr_hiz_R9: assert property (@(posedge clk) disable iff (!rstN)
    cbrActive |-> (dqOe == 2'b00));
endmodule

// File: tb/tb_edo_dram_emu.sv
module tb_edo_dram_emu;
  localparam int ROWS = 16, COLS = 16, SR = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic rasN = 1, lcasN = 1, ucasN = 1, weN = 1, oeN = 1;
  logic [9:0]  addr = '0;
  logic [15:0] dqIn = '0;
  logic [15:0] dqOut;
  logic [1:0]  dqOe;
  logic [3:0]  cbrRow;
  logic        selfRefresh;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] refm [ROWS][COLS];

  always #2 clk = ~clk;

  edo_dram_emu dut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .lcasN(lcasN), .ucasN(ucasN),
    .weN(weN), .oeN(oeN), .addr(addr), .dqIn(dqIn), .dqOut(dqOut),
    .dqOe(dqOe), .cbrRow(cbrRow), .selfRefresh(selfRefresh)
  );

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int r, input int c);
    return {4'(r), 4'(c), ~4'(r), 4'(r) ^ 4'(c)};
  endfunction

  task automatic endCycle;
    rasN = 1; lcasN = 1; ucasN = 1; oeN = 1; weN = 1;
    tick; tick;
  endtask

  task automatic writeEarly(input logic [9:0] ra, input logic [9:0] ca,
                            input logic [15:0] d, input logic [1:0] ln);
    rasN = 0; addr = ra; tick;
    weN = 0; dqIn = d; tick;
    addr = ca; dqIn = ~d; lcasN = ~ln[0]; ucasN = ~ln[1]; tick;
    endCycle;
  endtask

  task automatic readWord(input logic [9:0] ra, input logic [9:0] ca, input logic [1:0] ln,
                          output logic [15:0] d, output logic [1:0] oe);
    rasN = 0; addr = ra; tick;
    addr = ca; lcasN = ~ln[0]; ucasN = ~ln[1]; oeN = 0; tick;
    d = dqOut; oe = dqOe;
    endCycle;
  endtask

  task automatic cbrCycle(input int holdTicks);
    lcasN = 0; ucasN = 0; addr = 10'h3FF; tick;
    rasN = 0; oeN = 0; tick;
    for (int i = 0; i < holdTicks; i++) begin
      chk("R9 bus quiet in refresh", 32'(dqOe), 32'd0);
      tick;
    end
    endCycle;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [1:0]  oe;
    logic [3:0]  startRow;

    repeat (3) tick;
    chk("R1 dqOe in reset", 32'(dqOe), 0);
    rstN = 1; tick;
    chk("R1 dqOe after reset", 32'(dqOe), 0);
    chk("R1 cbrRow after reset", 32'(cbrRow), 0);
    chk("R1 selfRefresh after reset", 32'(selfRefresh), 0);

    // R2 R4 R6: full sweep, early writes then reads
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        writeEarly(10'(r), 10'(c), pat(r, c), 2'b11);
        refm[r][c] = pat(r, c);
      end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        readWord(10'(r), 10'(c), 2'b11, d, oe);
        chk("R4 sweep read data", 32'(d), 32'(refm[r][c]));
        chk("R4 sweep read oe", 32'(oe), 32'd3);
      end

    // R2: aliasing of upper address bits
    writeEarly(10'h3F5, 10'h2A7, 16'h1357, 2'b11); refm[5][7] = 16'h1357;
    readWord(10'd5, 10'd7, 2'b11, d, oe);
    chk("R2 aliased write", 32'(d), 32'h1357);

    // R5: byte-lane writes and reads
    writeEarly(10'd2, 10'd3, 16'hBEEF, 2'b01); refm[2][3][7:0] = 8'hEF;
    writeEarly(10'd2, 10'd4, 16'hCAFE, 2'b10); refm[2][4][15:8] = 8'hCA;
    readWord(10'd2, 10'd3, 2'b11, d, oe);
    chk("R5 low-lane write", 32'(d), 32'(refm[2][3]));
    readWord(10'd2, 10'd4, 2'b11, d, oe);
    chk("R5 high-lane write", 32'(d), 32'(refm[2][4]));
    readWord(10'd2, 10'd4, 2'b10, d, oe);
    chk("R5 high-lane read oe", 32'(oe), 32'd2);
    chk("R5 high-lane read data", 32'(d[15:8]), 32'(refm[2][4][15:8]));

    // R6: late write, data taken at CAS fall
    rasN = 0; addr = 10'd9; tick;
    addr = 10'd1; dqIn = 16'h4411; lcasN = 0; ucasN = 0; tick;
    dqIn = 16'h9922; weN = 0; tick;
    endCycle; refm[9][1] = 16'h4411;
    readWord(10'd9, 10'd1, 2'b11, d, oe);
    chk("R6 late write", 32'(d), 32'h4411);

    // R6: CAS and WE fall together
    rasN = 0; addr = 10'd9; tick;
    addr = 10'd2; dqIn = 16'h7070; weN = 0; lcasN = 0; ucasN = 0; tick;
    dqIn = 16'h0000; tick;
    endCycle; refm[9][2] = 16'h7070;
    readWord(10'd9, 10'd2, 2'b11, d, oe);
    chk("R6 simultaneous write", 32'(d), 32'h7070);

    // R6: page-mode writes with WE held low
    rasN = 0; addr = 10'd12; tick;
    weN = 0;
    for (int c = 0; c < 4; c++) begin
      addr = 10'(c); dqIn = 16'hD000 + 16'(c); lcasN = 0; ucasN = 0; tick;
      lcasN = 1; ucasN = 1; dqIn = 16'hFFFF; tick;
      refm[12][c] = 16'hD000 + 16'(c);
    end
    endCycle;
    for (int c = 0; c < 4; c++) begin
      readWord(10'd12, 10'(c), 2'b11, d, oe);
      chk("R6 page write", 32'(d), 32'(refm[12][c]));
    end

    // R7 R8: EDO hold and output gating
    rasN = 0; addr = 10'd7; tick;
    addr = 10'd0; lcasN = 0; ucasN = 0; oeN = 0; tick;
    chk("R7 first page read", 32'(dqOut), 32'(refm[7][0]));
    lcasN = 1; ucasN = 1; addr = 10'd1; tick;
    chk("R7 held after CAS rise oe", 32'(dqOe), 32'd3);
    chk("R7 held after CAS rise data", 32'(dqOut), 32'(refm[7][0]));
    tick;
    chk("R7 still held", 32'(dqOut), 32'(refm[7][0]));
    lcasN = 0; ucasN = 0; tick;
    chk("R7 next CAS fall data", 32'(dqOut), 32'(refm[7][1]));
    oeN = 1; #1;
    chk("R8 OE high releases", 32'(dqOe), 32'd0);
    oeN = 0; #1;
    chk("R8 OE low drives again", 32'(dqOe), 32'd3);
    weN = 0; #1;
    chk("R8 WE low releases", 32'(dqOe), 32'd0);
    weN = 1;
    rasN = 1; tick;
    chk("R8 RAS high with CAS low keeps data", 32'(dqOe), 32'd3);
    lcasN = 1; ucasN = 1; tick;
    chk("R8 idle sample releases", 32'(dqOe), 32'd0);
    endCycle;

    // R3: staggered lanes form one effective strobe
    rasN = 0; addr = 10'd12; tick;
    addr = 10'd0; lcasN = 0; oeN = 0; tick;
    chk("R3 first lane oe", 32'(dqOe), 32'd1);
    addr = 10'd1; ucasN = 0; tick;
    chk("R3 second lane joins oe", 32'(dqOe), 32'd3);
    chk("R3 second lane no new column", 32'(dqOut), 32'(refm[12][0]));
    lcasN = 1; tick;
    lcasN = 0; tick;
    chk("R3 lane toggle keeps column", 32'(dqOut), 32'(refm[12][0]));
    lcasN = 1; ucasN = 1; tick;
    lcasN = 0; tick;
    chk("R3 new strobe new column", 32'(dqOut), 32'(refm[12][1]));
    chk("R3 new strobe lane oe", 32'(dqOe), 32'd1);
    endCycle;

    // R9 R10: refresh-only cycles, counter wrap
    lcasN = 0; ucasN = 0; tick;
    rasN = 0; weN = 0; addr = 10'd5; dqIn = 16'h0BAD; tick;
    addr = 10'd7; tick;
    chk("R9 write ignored oe", 32'(dqOe), 32'd0);
    endCycle;
    readWord(10'd5, 10'd7, 2'b11, d, oe);
    chk("R9 array unchanged", 32'(d), 32'(refm[5][7]));
    chk("R10 step after refresh", 32'(cbrRow), 32'd1);
    startRow = cbrRow;
    for (int i = 0; i < ROWS; i++) begin
      cbrCycle(2);
      chk("R10 counter step", 32'(cbrRow), 32'(4'(startRow + 4'(i + 1))));
    end
    chk("R10 wrap", 32'(cbrRow), 32'(startRow));

    // R11: self-refresh flag
    lcasN = 0; ucasN = 0; tick;
    rasN = 0; tick;
    repeat (SR - 1) tick;
    chk("R11 flag not yet set", 32'(selfRefresh), 32'd0);
    tick;
    chk("R11 flag set", 32'(selfRefresh), 32'd1);
    rasN = 1; lcasN = 1; ucasN = 1; tick;
    chk("R11 flag cleared", 32'(selfRefresh), 32'd0);
    chk("R10 step after self refresh", 32'(cbrRow), 32'(4'(startRow + 4'd1)));
    tick;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule